// File: doc/BRIEF.md
# Serial Output Expander Driver

This block sits on the host side of a three-wire link to one or more latched shift-register output expanders connected in a chain. It takes a parallel word and a one-cycle start request. It then serialises the word onto a data wire and a shift-clock wire. When every bit has gone out, it gives a single pulse on a latch-clock wire, which moves the whole word onto the expanders' outputs in one step. The expanders' outputs therefore never show a partly shifted word.

Each bit goes through three phases: data setup, shift clock high and shift clock low. Each phase lasts `PHASE_CYC` system cycles, so the wire timing can be slowed to suit the cable and the receiving parts. The word length is `8 * NUM_DEV`, one byte for each chained device. The bit sent first ends up in the stage farthest from the host. While a transfer runs the block shows busy, and it gives a one-cycle done pulse when the transfer ends.

Top module: `serial_expander_drv`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ser_o`, `sclk_o` and `lclk_o` are all low.
- R2: A `start_i` sampled high while idle captures `word_i`. In the next cycle `busy_o` is high, `sclk_o` is low and `ser_o` carries bit W-1 of the captured word.
- R3: Each bit takes 3*PHASE_CYC cycles after its data is presented. `sclk_o` is low for the first PHASE_CYC cycles, high for the next PHASE_CYC cycles and low for the last PHASE_CYC cycles.
- R4: `ser_o` does not change in the cycle in which `sclk_o` rises, nor while `sclk_o` is high.
- R5: Exactly W = 8*NUM_DEV shift-clock rising edges occur per transfer. Bits are sent from bit W-1 down to bit 0 (most significant first).
- R6: After the last shift clock falls, `lclk_o` goes high for PHASE_CYC cycles, once per transfer. It is never high while `sclk_o` is high.
- R7: `done_o` is high for exactly one cycle: the first cycle in which `lclk_o` is low again. `busy_o` drops in that same cycle. The whole transfer lasts 3*PHASE_CYC*W + PHASE_CYC cycles.
- R8: While busy, `start_i` and any change on `word_i` have no effect on the wire sequence of the transfer in progress.
- R9: If `start_i` is high in the cycle `done_o` shows, a new transfer is accepted at the next clock edge with the `word_i` value present then.
- R10: Outside a transfer, `ser_o` holds the last bit it sent (low after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer request, sampled when idle |
| word_i | input | 8*NUM_DEV | Parallel word to send |
| busy_o | output | 1 | High while a transfer is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| ser_o | output | 1 | Serial data wire |
| sclk_o | output | 1 | Shift-clock wire |
| lclk_o | output | 1 | Latch-clock wire |

## Verification
The assertions assume that `start_i` and `word_i` are synchronous to `clk`, that `word_i` only needs to be valid in the cycle a request is accepted, and that both parameters are at least one. The stimulus changes inputs only on the falling edge. It gives requests while idle, while busy (with `word_i` changed mid-transfer) and exactly at the done cycle. Every request therefore falls on one of the accept-or-ignore cases that the properties describe.

// File: rtl/sxd_pkg.sv
package sxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_CLK_HI = 3'd2,
        ST_CLK_LO = 3'd3,
        ST_LATCH  = 3'd4
    } xfer_state_e;

    typedef struct packed {
        xfer_state_e state;
        logic        ser;
        logic        sclk;
        logic        lclk;
        logic        done;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RESET = '{
        state: ST_IDLE,
        ser:   1'b0,
        sclk:  1'b0,
        lclk:  1'b0,
        done:  1'b0
    };

endpackage

// File: rtl/sxd_phase_timer.sv
// Counts system cycles within one wire phase; flags the last cycle.
module sxd_phase_timer #(
    parameter int unsigned PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic end_o
);
    localparam int unsigned CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign end_o = run_i && (cnt_q == LAST);

    always_comb begin
        if (!run_i || end_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sxd_bit_shifter.sv
// Holds the word being sent, most significant bit first, and counts bits left.
module sxd_bit_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    output logic         next_bit_o,
    output logic         last_o
);
    localparam int unsigned LW = $clog2(W);

    logic [W-1:0]  sh_d, sh_q;
    logic [LW-1:0] left_d, left_q;

    assign next_bit_o = sh_q[W-2];
    assign last_o     = (left_q == '0);

    always_comb begin
        sh_d   = sh_q;
        left_d = left_q;
        if (load_i) begin
            sh_d   = word_i;
            left_d = LW'(W - 1);
        end else if (shift_i) begin
            sh_d   = {sh_q[W-2:0], 1'b0};
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else begin
            sh_q   <= sh_d;
            left_q <= left_d;
        end
    end
endmodule

// File: rtl/serial_expander_drv.sv
// Drives data, shift clock and latch clock for a chain of latched expanders.
module serial_expander_drv
    import sxd_pkg::*;
#(
    parameter int unsigned NUM_DEV   = 2,
    parameter int unsigned PHASE_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [8*NUM_DEV-1:0] word_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 ser_o,
    output logic                 sclk_o,
    output logic                 lclk_o
);
    localparam int unsigned W = 8 * NUM_DEV;

    ctrl_regs_t r_d, r_q;
    logic       phase_end;
    logic       load, shift;
    logic       next_bit, last_bit;
    logic       active;

    assign active = (r_q.state != ST_IDLE);

    sxd_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (active),
        .end_o (phase_end)
    );

    sxd_bit_shifter #(
        .W (W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .word_i     (word_i),
        .shift_i    (shift),
        .next_bit_o (next_bit),
        .last_o     (last_bit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        shift    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    load      = 1'b1;
                    r_d.state = ST_SETUP;
                    r_d.ser   = word_i[W-1];
                end
            end
            ST_SETUP: begin
                if (phase_end) begin
                    r_d.state = ST_CLK_HI;
                    r_d.sclk  = 1'b1;
                end
            end
            ST_CLK_HI: begin
                if (phase_end) begin
                    r_d.state = ST_CLK_LO;
                    r_d.sclk  = 1'b0;
                end
            end
            ST_CLK_LO: begin
                if (phase_end) begin
                    if (last_bit) begin
                        r_d.state = ST_LATCH;
                        r_d.lclk  = 1'b1;
                    end else begin
                        shift     = 1'b1;
                        r_d.state = ST_SETUP;
                        r_d.ser   = next_bit;
                    end
                end
            end
            ST_LATCH: begin
                if (phase_end) begin
                    r_d.state = ST_IDLE;
                    r_d.lclk  = 1'b0;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d = CTRL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTRL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = active;
    assign done_o = r_q.done;
    assign ser_o  = r_q.ser;
    assign sclk_o = r_q.sclk;
    assign lclk_o = r_q.lclk;
endmodule

// File: rtl/serial_expander_drv_chk.sv
module serial_expander_drv_chk #(
    parameter int unsigned W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic ser_o,
    input logic sclk_o,
    input logic lclk_o
);
    logic        sclk_prev;
    logic [15:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            sclk_prev <= sclk_o;
            if (done_o) begin
                rise_cnt <= '0;
            end else if (sclk_o && !sclk_prev) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    a_r1_idle_wires_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !lclk_o));

    a_r2_accept_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !sclk_o && !done_o));

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(ser_o));

    a_r5_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lclk_o) |-> (rise_cnt == 16'(W)));

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_o && lclk_o));

    a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($fell(lclk_o) && !busy_o));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind serial_expander_drv serial_expander_drv_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .ser_o   (ser_o),
    .sclk_o  (sclk_o),
    .lclk_o  (lclk_o)
);

// File: tb/serial_expander_drv_tb_top.sv
module serial_expander_drv_tb_top;
    localparam int NDEV = 2;
    localparam int DIV  = 2;
    localparam int W    = 8 * NDEV;
    localparam int SHIFT_CYC = 3 * DIV * W;
    localparam int END_K     = SHIFT_CYC + DIV;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] word = '0;
    logic         busy, done, ser, sclk, lclk;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    serial_expander_drv #(.NUM_DEV(NDEV), .PHASE_CYC(DIV)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .word_i  (word),
        .busy_o  (busy),
        .done_o  (done),
        .ser_o   (ser),
        .sclk_o  (sclk),
        .lclk_o  (lclk)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: elapsed cycles since acceptance define the wires.
    bit           m_active = 1'b0;
    int           m_k = 0;
    logic [W-1:0] m_word = '0;
    logic         m_done = 1'b0;
    logic         m_hold = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active <= 1'b0; m_k <= 0; m_done <= 1'b0; m_hold <= 1'b0; m_word <= '0;
        end else begin
            m_done <= 1'b0;
            if (m_active) begin
                if (m_k + 1 == END_K) begin
                    m_active <= 1'b0;
                    m_done   <= 1'b1;
                    m_hold   <= m_word[0];
                end else begin
                    m_k <= m_k + 1;
                end
            end else if (start) begin
                m_active <= 1'b1;
                m_k      <= 0;
                m_word   <= word;
            end
        end
    end

    // Per-cycle comparison against the reference (R3, R5, R6, R7, R8, R10).
    logic prev_sclk = 1'b0, prev_lclk = 1'b0, prev_ser = 1'b0;
    int   rises = 0, lpulses = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_ser, e_sclk, e_lclk, e_busy;
            if (m_active) begin
                e_busy = 1'b1;
                if (m_k < SHIFT_CYC) begin
                    e_ser  = m_word[W - 1 - (m_k / (3 * DIV))];
                    e_sclk = (((m_k % (3 * DIV)) / DIV) == 1);
                    e_lclk = 1'b0;
                end else begin
                    e_ser  = m_word[0];
                    e_sclk = 1'b0;
                    e_lclk = 1'b1;
                end
            end else begin
                e_busy = 1'b0;
                e_ser  = m_hold;     // R10 hold when idle
                e_sclk = 1'b0;
                e_lclk = 1'b0;
            end
            check(busy == e_busy, "R7", "busy_o", busy, e_busy);
            check(done == m_done, "R7", "done_o", done, m_done);
            check(ser  == e_ser,  "R5", "ser_o",  ser,  e_ser);
            check(sclk == e_sclk, "R3", "sclk_o", sclk, e_sclk);
            check(lclk == e_lclk, "R6", "lclk_o", lclk, e_lclk);
            if (sclk && !prev_sclk) begin
                rises++;
                check(ser == prev_ser, "R4", "ser_o at sclk rise", ser, prev_ser);
            end
            if (lclk && !prev_lclk) lpulses++;
            if (done) begin
                check(rises == W, "R5", "shift clocks per transfer", rises, W);
                check(lpulses == 1, "R6", "latch pulses per transfer", lpulses, 1);
                rises = 0;
                lpulses = 0;
            end
            prev_sclk = sclk;
            prev_lclk = lclk;
            prev_ser  = ser;
        end
    end

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic send(input logic [W-1:0] w);
        start = 1'b1;
        word  = w;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy_o after start", busy, 1);
        check(ser == w[W-1], "R2", "first bit is MSB", ser, w[W-1]);
        wait_done();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy_o in reset", busy, 0);
        check(done == 1'b0, "R1", "done_o in reset", done, 0);
        check(ser  == 1'b0, "R1", "ser_o in reset",  ser,  0);
        check(sclk == 1'b0, "R1", "sclk_o in reset", sclk, 0);
        check(lclk == 1'b0, "R1", "lclk_o in reset", lclk, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        send(16'hA5C3);
        send(16'h0000);
        send(16'hFFFF);

        // R8: extra start and word change while busy are ignored
        start = 1'b1;
        word  = 16'h8001;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1;
        word  = 16'h7FFE;
        @(negedge clk);
        start = 1'b0;
        word  = 16'h1234;
        wait_done();
        @(negedge clk);

        // R9: start held high across done picks up the next word
        start = 1'b1;
        word  = 16'h3C96;
        @(negedge clk);
        wait_done();
        word = 16'h6A51;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "back-to-back accept", busy, 1);
        check(ser == 1'b0, "R9", "new word MSB", ser, 0);
        wait_done();
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule